// File: doc/BRIEF.md
# Frame-Synchronized Serial Transmitter with Safe Start

This block is the transmit half of a serial port that runs as a slave. An external device supplies both the bit clock and the frame sync. A host or DMA engine writes parallel words into a one-word holding register. On each frame sync the held word moves into a shift register. The shift register then drives the data pin one bit per bit-clock rising edge, most significant bit first. Both external strobes are asynchronous to the block's core clock. Each one passes through a two-flop synchronizer and a rising-edge detector.

Starting the transmitter while the external master is already framing is a hazard. A frame sync can arrive before the host has had a chance to load the first word. The stale contents then go out, and every later word lands one channel late. To prevent this, the block offers a guarded start. After the enable rises, the first frame sync only arms the transmitter and nothing is driven. Real transfers begin on the second frame sync, which leaves almost a whole frame period to load the first word. The frame-sync edge detector runs even while the transmitter is held idle, and its pulse is brought out so the host can observe it.

Any frame sync that finds the holding register empty while transmitting sets a sticky underrun flag. Clearing the enable returns the block to idle and restarts the arming sequence.

Top module: `safe_serial_tx`

## Requirements
- R1: After reset the data pin is 0, txReady is 0 and underrun is 0.
- R2: While enable is low, writes are ignored, txReady stays 0 and the data pin stays 0 even when frame syncs and bit clocks arrive.
- R3: With safeStartEn high, the first frame sync after enable rises drives no data and sets no underrun. A word written after it is sent on the second frame sync.
- R4: A loaded word appears MSB first: the MSB is on the pin after the frame sync, and each bit-clock rising edge presents the next bit. After DATA_W rising edges the pin returns to 0.
- R5: While enabled and armed or running, txReady is 1 when the holding register is empty. It drops after an accepted write and returns to 1 once a frame sync moves the word into the shifter.
- R6: A write while txReady is 0 is ignored: the held word is not replaced.
- R7: A frame sync while running with an empty holding register sets underrun and retransmits the stale word still held in the holding register.
- R8: underrun stays set until underrunClr is pulsed, including across later successful frames.
- R9: With safeStartEn low, the first frame sync after enable already loads the shifter. After a restart, an empty register sends zeros and sets underrun.
- R10: Dropping enable mid-word returns the pin to 0 and empties the holding register. The next enable restarts the arming sequence.
- R11: fsEdge pulses high for exactly one core-clock cycle per rising edge of the frame sync input, whether or not the transmitter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmitter enable; low forces idle |
| safeStartEn | input | 1 | 1 selects the guarded start on the second frame sync |
| bitClkPin | input | 1 | External bit clock, asynchronous |
| frameSyncPin | input | 1 | External frame sync, asynchronous |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | DATA_W | Word to transmit |
| underrunClr | input | 1 | Clears the sticky underrun flag |
| serialOut | output | 1 | Serial data pin |
| txReady | output | 1 | Holding register can accept a word |
| underrun | output | 1 | Sticky underrun flag |
| fsEdge | output | 1 | One-cycle pulse per detected frame-sync rising edge |

## Verification
The serial path is driven with words that have different bit patterns: 0xA5 and 0x5A alternate, 0x3C and 0xC3 form nibble blocks, 0x81 has its ends set, and 0x96 is used as well. These patterns separate correct MSB-first order from reversed order, dropped bits or an extra shift. The start sequence is tried in both modes. In guarded mode, a silent first frame must be followed by the correct word. In unguarded mode, the first sync must load at once. Frames with no write in between separate a stale retransmission from a zero word. The tests also cover dropping the enable mid-word and writing while disabled or full.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN
  } txState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic flush;         // hold datapath idle and empty
    logic accept;        // host writes may be taken
    logic load;          // move holding register into shifter
    logic flagUnderrun;  // load found the holding register empty
  } txStrobes_t;

endpackage

// File: rtl/sertx_edge_sync.sv
module sertx_edge_sync (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rise
);

  logic meta;
  logic stable;
  logic stableDly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta      <= 1'b0;
      stable    <= 1'b0;
      stableDly <= 1'b0;
    end else begin
      meta      <= asyncIn;
      stable    <= meta;
      stableDly <= stable;
    end
  end

  assign rise = stable & ~stableDly;

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       safeStartEn,
  input  logic       fsRise,
  input  logic       regFull,
  output txStrobes_t strb
);

  txState_t state;
  txState_t stateNxt;

  always_comb begin
    stateNxt = state;
    if (!enable) begin
      stateNxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: stateNxt = safeStartEn ? ST_ARM : ST_RUN;
        ST_ARM:  stateNxt = fsRise ? ST_RUN : ST_ARM;
        ST_RUN:  stateNxt = ST_RUN;
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb.flush        = !enable || (state == ST_IDLE);
    strb.accept       = enable && (state != ST_IDLE);
    strb.load         = enable && (state == ST_RUN) && fsRise;
    strb.flagUnderrun = enable && (state == ST_RUN) && fsRise && !regFull;
  end

  // R3: the arming sync moves the transmitter into the running state
  a_r3_first_sync_arms: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARM && enable && fsRise) |=> (state == ST_RUN));

  // R3: no transfer can start while waiting for the arming sync
  a_r3_armed_is_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARM) |-> !strb.flagUnderrun);

endmodule

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strb,
  input  logic              bitRise,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              underrunClr,
  output logic              serialOut,
  output logic              txReady,
  output logic              underrun,
  output logic              regFull
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shReg;
  logic [CNT_W-1:0]  bitsLeft;
  logic              wrAccept;

  assign wrAccept = strb.accept && wrEn && !regFull;
  assign txReady  = strb.accept && !regFull;

  // holding register and its occupancy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      regFull <= 1'b0;
    end else if (strb.flush) begin
      holdReg <= '0;
      regFull <= 1'b0;
    end else if (wrAccept) begin
      holdReg <= wrData;
      regFull <= 1'b1;
    end else if (strb.load) begin
      regFull <= 1'b0;
    end
  end

  // shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitsLeft <= '0;
    end else if (strb.flush) begin
      shReg    <= '0;
      bitsLeft <= '0;
    end else if (strb.load) begin
      shReg    <= holdReg;
      bitsLeft <= FULL_CNT;
    end else if (bitRise && bitsLeft != '0) begin
      shReg    <= {shReg[DATA_W-2:0], 1'b0};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign serialOut = (bitsLeft != '0) ? shReg[DATA_W-1] : 1'b0;

  // sticky underrun; a new event wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  underrun <= 1'b0;
    else if (strb.flagUnderrun) underrun <= 1'b1;
    else if (underrunClr)       underrun <= 1'b0;
  end

  a_r5_write_fills: assert property (@(posedge clk) disable iff (!rstN)
    wrAccept |=> !txReady);

  a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagUnderrun |=> underrun);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !underrunClr) |=> underrun);

  a_r4_idle_after_word: assert property (@(posedge clk) disable iff (!rstN)
    (bitsLeft == CNT_W'(1) && bitRise && !strb.load && !strb.flush) |=> !serialOut);

endmodule

// File: rtl/safe_serial_tx.sv
module safe_serial_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              safeStartEn,
  input  logic              bitClkPin,
  input  logic              frameSyncPin,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              underrunClr,
  output logic              serialOut,
  output logic              txReady,
  output logic              underrun,
  output logic              fsEdge
);

  logic       bitRise;
  logic       fsRise;
  logic       regFull;
  txStrobes_t strb;

  sertx_edge_sync i_bitSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(bitClkPin),
    .rise   (bitRise)
  );

  sertx_edge_sync i_fsSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(frameSyncPin),
    .rise   (fsRise)
  );

  sertx_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .safeStartEn(safeStartEn),
    .fsRise     (fsRise),
    .regFull    (regFull),
    .strb       (strb)
  );

  sertx_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .bitRise    (bitRise),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .underrunClr(underrunClr),
    .serialOut  (serialOut),
    .txReady    (txReady),
    .underrun   (underrun),
    .regFull    (regFull)
  );

  assign fsEdge = fsRise;

  a_r2_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !serialOut);

endmodule

// File: tb/test_safe_serial_tx.sv
`timescale 1ns/1ps
module test_safe_serial_tx;

  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              safeStartEn = 1'b1;
  logic              bitClkPin = 1'b0;
  logic              frameSyncPin = 1'b0;
  logic              wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              underrunClr = 1'b0;
  logic              serialOut;
  logic              txReady;
  logic              underrun;
  logic              fsEdge;

  int checkCnt = 0;
  int failCnt  = 0;
  int fsSent   = 0;
  int fsSeen   = 0;

  always #2.5 clk = ~clk;

  safe_serial_tx #(.DATA_W(DATA_W)) i_safe_serial_tx (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .safeStartEn (safeStartEn),
    .bitClkPin   (bitClkPin),
    .frameSyncPin(frameSyncPin),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .underrunClr (underrunClr),
    .serialOut   (serialOut),
    .txReady     (txReady),
    .underrun    (underrun),
    .fsEdge      (fsEdge)
  );

  always @(negedge clk) if (fsEdge) fsSeen++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [DATA_W-1:0] w);
    wrEn = 1'b1; wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
    waitCyc(1);
  endtask

  task automatic bitPulse();
    bitClkPin = 1'b1; waitCyc(4);
  endtask

  task automatic bitLow();
    bitClkPin = 1'b0; waitCyc(4);
  endtask

  // one frame: sync then DATA_W bit edges, checking each bit
  task automatic frameCheck(input string req, input logic [DATA_W-1:0] w);
    frameSyncPin = 1'b1; fsSent++;
    waitCyc(4);
    check(req, serialOut, w[DATA_W-1]);
    frameSyncPin = 1'b0;
    waitCyc(4);
    for (int i = DATA_W - 2; i >= 0; i--) begin
      bitPulse();
      check(req, serialOut, w[i]);
      bitLow();
    end
    bitPulse();
    check({req, " line idle after word"}, serialOut, 1'b0);
    bitLow();
  endtask

  // a frame during which the line must stay low
  task automatic silentFrame(input string req);
    frameSyncPin = 1'b1; fsSent++;
    waitCyc(4);
    check(req, serialOut, 1'b0);
    frameSyncPin = 1'b0;
    waitCyc(4);
    for (int i = 0; i < 3; i++) begin
      bitPulse();
      check(req, serialOut, 1'b0);
      bitLow();
    end
  endtask

  task automatic testReset();
    check("R1 serialOut", serialOut, 1'b0);
    check("R1 txReady", txReady, 1'b0);
    check("R1 underrun", underrun, 1'b0);
  endtask

  task automatic testDisabled();
    hostWrite(8'hA5);
    check("R2 txReady while disabled", txReady, 1'b0);
    silentFrame("R2 quiet while disabled");
    check("R11 edge seen while disabled", fsSeen, fsSent);
  endtask

  task automatic testSafeStart();
    safeStartEn = 1'b1; enable = 1'b1;
    waitCyc(2);
    check("R5 ready when empty", txReady, 1'b1);
    check("R2 earlier write discarded (R5 ready)", txReady, 1'b1);
    silentFrame("R3 first sync silent");
    check("R3 no underrun on arming sync", underrun, 1'b0);
    hostWrite(8'hA5);
    check("R5 not ready after write", txReady, 1'b0);
    hostWrite(8'h3C);
    frameCheck("R3 R4 R6 first word A5", 8'hA5);
    check("R5 ready after load", txReady, 1'b1);
    check("R3 no underrun", underrun, 1'b0);
  endtask

  task automatic testUnderrun();
    frameCheck("R7 stale word resent", 8'hA5);
    check("R7 underrun set", underrun, 1'b1);
    hostWrite(8'hC3);
    frameCheck("R4 word C3", 8'hC3);
    check("R8 underrun sticky", underrun, 1'b1);
    underrunClr = 1'b1; @(negedge clk); underrunClr = 1'b0;
    waitCyc(1);
    check("R8 underrun cleared", underrun, 1'b0);
  endtask

  task automatic testEnableDrop();
    hostWrite(8'h96);
    frameSyncPin = 1'b1; fsSent++;
    waitCyc(4);
    check("R4 word 96 msb", serialOut, 1'b1);
    frameSyncPin = 1'b0; waitCyc(4);
    bitPulse(); bitLow();
    bitPulse(); bitLow();
    check("R4 word 96 bit5", serialOut, 1'b0);
    bitPulse(); bitLow();
    check("R4 word 96 bit4", serialOut, 1'b1);
    enable = 1'b0;
    waitCyc(2);
    check("R10 line low after drop", serialOut, 1'b0);
    check("R10 not ready while idle", txReady, 1'b0);
    enable = 1'b1;
    waitCyc(2);
    check("R10 register emptied", txReady, 1'b1);
    hostWrite(8'h5A);
    silentFrame("R10 rearmed first sync silent");
    frameCheck("R10 R4 word 5A", 8'h5A);
    check("R10 no underrun", underrun, 1'b0);
  endtask

  task automatic testNoSafeStart();
    enable = 1'b0; safeStartEn = 1'b0;
    waitCyc(2);
    enable = 1'b1;
    waitCyc(2);
    hostWrite(8'h81);
    frameCheck("R9 immediate load 81", 8'h81);
    check("R9 no underrun", underrun, 1'b0);
    enable = 1'b0; waitCyc(2);
    enable = 1'b1; waitCyc(2);
    frameCheck("R9 empty sends zeros", 8'h00);
    check("R9 underrun on first sync", underrun, 1'b1);
    check("R11 one pulse per sync", fsSeen, fsSent);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end

  initial begin
    waitCyc(3);
    testReset();
    rstN = 1'b1;
    waitCyc(2);
    testDisabled();
    testSafeStart();
    testUnderrun();
    testEnableDrop();
    testNoSafeStart();
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end

endmodule